// File: doc/BRIEF.md
# Asymmetric High/Low Carrier Generator

This block produces a periodic square-wave carrier. The time the wave spends high and the time it spends low are each programmed in clock cycles by their own 8-bit count input. Frequency and duty cycle can therefore be set independently. A single up-counter measures the current phase. It is compared against whichever count belongs to the level being driven at that moment. When they match, the counter restarts at one, the level flips and the other count becomes the active compare value. The waveform then repeats for as long as the block stays enabled.

The compare value is captured at each phase boundary. A count that changes in the middle of a phase only shapes the next phase of that level. A single-cycle strobe marks every rising edge of the carrier so that a downstream modulator can align to carrier periods. Clock division, register decoding and modulation belong to neighbouring logic.

Top module: `carrier_gen`

## Requirements
- R1: While `enable` is low, from the next clock edge onward `carrier_o` is 0, `phase_o` is 1 (the high phase is armed for the next start) and `rise_o` is 0.
- R2: On the first clock edge with `enable` high after an idle period, `carrier_o` goes to 1 and stays 1 for exactly `high_cnt` cycles.
- R3: While `phase_o` is 1 (high phase), the carrier stays high until the counter equals the captured high count, and it goes low on the next edge.
- R4: While `phase_o` is 0 (low phase), the carrier stays low for exactly the captured low count in cycles, then returns high.
- R5: The internal counter runs from 1 up to the active compare value and restarts at 1 after each match. It never exceeds the compare value.
- R6: While enabled, one carrier period equals `high_cnt + low_cnt` clock cycles and repeats without any further input. This gives 2 cycles at the minimum setting (1/1) and 510 at the maximum (255/255).
- R7: A count changed during a phase takes effect only at the next boundary where that level starts. The phase in progress keeps its captured length.
- R8: `rise_o` is high for exactly one cycle, in the first cycle of each high phase, and at no other time.
- R9: A count value of 0 is not a legal setting and is treated as 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the generator when high; idle and rearm when low |
| high_cnt | input | 8 | High-phase length in cycles (1..255) |
| low_cnt | input | 8 | Low-phase length in cycles (1..255) |
| carrier_o | output | 1 | Carrier square wave |
| phase_o | output | 1 | 1 = high phase active or armed, 0 = low phase active |
| rise_o | output | 1 | One-cycle strobe at each carrier rising edge |

## Verification
The bench drives a symmetric setting, a strongly asymmetric one and both extremes (1/1 and 255/255). These show whether the two counts are routed to the correct phases, whether the length is off by one, and whether the counter wraps at full width. Rewriting the counts in the middle of a phase shows whether the captured value is held until the boundary. Dropping `enable` mid-phase and raising it again checks that the next start is rearmed to a full high phase. Zero counts probe the clamp to one. A behavioural down-counting model is compared with every output on every cycle, and the spacing between strobes is also measured against H+L.

// File: rtl/cg_pkg.sv
package cg_pkg;
  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } phase_e;
endpackage

// File: rtl/cg_counter.sv
module cg_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic [W-1:0] cmp,
  output logic [W-1:0] cnt,
  output logic         match
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_n;

  always_comb begin
    if (restart) cnt_n = ONE;
    else         cnt_n = cnt + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= ONE;
    else        cnt <= cnt_n;
  end

  assign match = (cnt == cmp);

  // counter never reads zero
  p_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n) cnt != '0);
endmodule

// File: rtl/cg_phase_ctrl.sv
module cg_phase_ctrl
  import cg_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable,
  input  logic         match,
  input  logic [W-1:0] high_val,
  input  logic [W-1:0] low_val,
  output logic         running,
  output phase_e       phase,
  output logic         carrier,
  output logic         rise,
  output logic [W-1:0] cmp
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] high_cl, low_cl;
  logic         running_n, carrier_n, rise_n;
  phase_e       phase_n;
  logic [W-1:0] cmp_n;

  assign high_cl = (high_val == '0) ? ONE : high_val;
  assign low_cl  = (low_val  == '0) ? ONE : low_val;

  always_comb begin
    running_n = running;
    phase_n   = phase;
    carrier_n = carrier;
    cmp_n     = cmp;
    rise_n    = 1'b0;
    if (!enable) begin
      running_n = 1'b0;
      phase_n   = PH_HIGH;
      carrier_n = 1'b0;
    end else if (!running) begin
      running_n = 1'b1;
      phase_n   = PH_HIGH;
      carrier_n = 1'b1;
      cmp_n     = high_cl;
      rise_n    = 1'b1;
    end else if (match) begin
      if (phase == PH_HIGH) begin
        phase_n   = PH_LOW;
        carrier_n = 1'b0;
        cmp_n     = low_cl;
      end else begin
        phase_n   = PH_HIGH;
        carrier_n = 1'b1;
        cmp_n     = high_cl;
        rise_n    = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      phase   <= PH_HIGH;
      carrier <= 1'b0;
      rise    <= 1'b0;
      cmp     <= ONE;
    end else begin
      running <= running_n;
      phase   <= phase_n;
      carrier <= carrier_n;
      rise    <= rise_n;
      cmp     <= cmp_n;
    end
  end

  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!carrier && phase == PH_HIGH && !rise));
  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !running) |=> (carrier && rise));
  p_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && running && match && phase == PH_HIGH) |=> !carrier);
  p_lowhold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && running && !match && phase == PH_LOW) |=> !carrier);
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && running && !match) |=> $stable(cmp));
  p_cmp_nz_r9: assert property (@(posedge clk) disable iff (!rst_n) cmp != '0);
endmodule

// File: rtl/carrier_gen.sv
module carrier_gen
  import cg_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [CNT_W-1:0] high_cnt,
  input  logic [CNT_W-1:0] low_cnt,
  output logic             carrier_o,
  output logic             phase_o,
  output logic             rise_o
);
  logic             running, match, restart;
  logic [CNT_W-1:0] cmp, cnt;
  phase_e           phase;

  assign restart = !enable || !running || match;

  cg_counter #(.W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .cmp     (cmp),
    .cnt     (cnt),
    .match   (match)
  );

  cg_phase_ctrl #(.W(CNT_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .match    (match),
    .high_val (high_cnt),
    .low_val  (low_cnt),
    .running  (running),
    .phase    (phase),
    .carrier  (carrier_o),
    .rise     (rise_o),
    .cmp      (cmp)
  );

  assign phase_o = (phase == PH_HIGH);

  p_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (cnt <= cmp));
  p_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && running && match) |=> (cnt == 1));
  p_rise_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |-> (carrier_o && !$past(carrier_o)));
  p_rise_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(carrier_o) |-> rise_o);
endmodule

// File: tb/tb_carrier_gen.sv
`timescale 1ns/1ps
module tb_carrier_gen;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       enable;
  logic [7:0] high_cnt, low_cnt;
  logic       carrier_o, phase_o, rise_o;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;
  int cyc     = 0;

  // behavioural reference state
  bit m_run, m_lvl, m_ph, m_rise;
  int m_rem;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  carrier_gen dut (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .high_cnt(high_cnt), .low_cnt(low_cnt),
    .carrier_o(carrier_o), .phase_o(phase_o), .rise_o(rise_o)
  );

  function automatic int cl(input logic [7:0] v);
    return (v == 0) ? 1 : int'(v);
  endfunction

  task automatic model_update();
    if (!enable) begin
      m_run = 0; m_lvl = 0; m_ph = 1; m_rise = 0;
    end else if (!m_run) begin
      m_run = 1; m_lvl = 1; m_ph = 1; m_rem = cl(high_cnt); m_rise = 1;
    end else if (m_rem == 1) begin
      if (m_ph) begin
        m_ph = 0; m_lvl = 0; m_rem = cl(low_cnt); m_rise = 0;
      end else begin
        m_ph = 1; m_lvl = 1; m_rem = cl(high_cnt); m_rise = 1;
      end
    end else begin
      m_rem = m_rem - 1; m_rise = 0;
    end
  endtask

  task automatic compare(input string tag);
    vectors++;
    if (carrier_o !== m_lvl || phase_o !== m_ph || rise_o !== m_rise) begin
      fails++;
      $display("FAIL %s cycle %0d: actual carrier=%b phase=%b rise=%b expected carrier=%b phase=%b rise=%b",
               tag, cyc, carrier_o, phase_o, rise_o, m_lvl, m_ph, m_rise);
    end
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    model_update();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic run(input string tag, input int n);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  // R6: spacing of strobes must equal H+L
  task automatic period_check(input logic [7:0] h, input logic [7:0] l, input int n);
    int last;
    int seen;
    last = -1; seen = 0;
    high_cnt = h; low_cnt = l;
    for (int i = 0; i < n; i++) begin
      step("R6");
      if (rise_o) begin
        if (last >= 0) begin
          vectors++;
          if (i - last != cl(h) + cl(l)) begin
            fails++;
            $display("FAIL R6 period: actual=%0d expected=%0d", i - last, cl(h) + cl(l));
          end
          seen++;
        end
        last = i;
      end
    end
    vectors++;
    if (seen == 0) begin
      fails++;
      $display("FAIL R6 no full period: actual=0 expected>0");
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog (all R): actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 0; enable = 0; high_cnt = 8'd3; low_cnt = 8'd5;
    m_run = 0; m_lvl = 0; m_ph = 1; m_rise = 0; m_rem = 0;
    repeat (3) @(negedge clk);
    compare("R1 reset");
    rst_n = 1;
    run("R1 idle", 5);

    // R2 R3 R4: asymmetric 3/5
    enable = 1;
    run("R2 R3 R4", 40);
    // strongly asymmetric 10/2
    high_cnt = 8'd10; low_cnt = 8'd2;
    run("R3 R4 asym", 50);
    // R5 R6 minimum setting
    high_cnt = 8'd1; low_cnt = 8'd1;
    run("R5 R6 min", 20);
    period_check(8'd3, 8'd5, 40);
    period_check(8'd1, 8'd1, 12);

    // R7: rewrite counts mid-phase
    enable = 0; high_cnt = 8'd4; low_cnt = 8'd4;
    run("R1", 2);
    enable = 1;
    run("R7", 2);
    high_cnt = 8'd7; low_cnt = 8'd2;
    run("R7 change", 30);

    // R1 R2: drop enable mid-phase and restart
    high_cnt = 8'd6; low_cnt = 8'd3;
    run("R2", 3);
    enable = 0;
    run("R1 drop", 4);
    enable = 1;
    run("R2 restart", 25);

    // R9: zero counts act as one
    high_cnt = 8'd0; low_cnt = 8'd0;
    run("R9", 12);
    period_check(8'd0, 8'd2, 15);

    // R6 R5: maximum setting, no wrap
    period_check(8'd255, 8'd255, 1100);
    period_check(8'd255, 8'd1, 600);

    enable = 0;
    run("R1 final", 4);
    done = 1;
    summary();
    $finish;
  end
endmodule